// File: doc/BRIEF.md
# Instruction-Address Breakpoint Comparator Bank

This block holds a small, parameterised set of breakpoint slots that watch the instruction-fetch stream of a core. Each slot owns a 64-bit address value and a 32-bit control word. A configuration port writes either register of any slot, and a combinational read port returns them. On every fetch probe the block compares the fetch PC against all enabled slots. It qualifies each comparison with the slot's privilege filter and its breakpoint type. One cycle after the probe it reports whether any slot fired, which slot that was, and the PC that fired it.

Only plain address-match breakpoints are honoured. The control word still stores the byte-select, security, linking and type fields, so debug software sees a full layout. Apart from the type field, the match logic does not consult the linking and security fields. Control bits outside the defined fields are never stored.

Top module: `bp_cmp_bank`

## Requirements
- R1: After reset `hit` is 0 and every slot reads back 0 in both its value and its control register, so no slot is enabled.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the value register (`cfg_sel`=0) or its low 32 bits into the control register (`cfg_sel`=1) of slot `cfg_idx`. The write takes effect at that clock edge and is visible on `rd_data` (selected by `rd_idx`, `rd_sel`) afterwards.
- R3: Control bits outside the mask 0x00FFE1E7 are discarded on write and always read as zero. The kept bits are: enable bit 0, privilege filter bits 2:1, byte select bits 8:5, security/higher-level bits 15:13, link number bits 19:16 and type bits 23:20.
- R4: A slot whose enable bit (control bit 0) is 0 never produces a hit.
- R5: A slot fires only when its type field (control bits 23:20) is 0, which means plain address match. Any non-zero type suppresses the hit.
- R6: The privilege filter (control bits 2:1) gates each slot by `probe_el`. A value of 2'b11 allows levels 0 and 1, 2'b10 allows level 0 only, 2'b01 allows level 1 only, and 2'b00 allows none. Levels 2 and 3 never match.
- R7: A hit requires the 64-bit `probe_pc` to equal the slot's value register exactly. A PC that differs in any bit does not fire.
- R8: When several slots fire on one probe, `hit_idx` reports the lowest slot number.
- R9: The outputs are registered. `hit` is 1 in the cycle after a probe with `probe_valid`=1 that fired, and in that cycle `hit_pc` equals the probed PC. A probe with `probe_valid`=0 never produces a hit.
- R10: A write whose `cfg_idx` is not below the slot count changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | IDX_W | Slot number for the write |
| cfg_sel | input | 1 | 0 = value register, 1 = control register |
| cfg_wdata | input | 64 | Write data (control uses bits 31:0) |
| rd_idx | input | IDX_W | Slot number for readback |
| rd_sel | input | 1 | 0 = value register, 1 = control register |
| rd_data | output | 64 | Combinational readback (0 for absent slots) |
| probe_valid | input | 1 | Fetch probe strobe |
| probe_pc | input | 64 | Fetch PC |
| probe_el | input | 2 | Privilege level of the fetch |
| hit | output | 1 | Registered breakpoint hit |
| hit_idx | output | IDX_W | Lowest matching slot, valid with `hit` |
| hit_pc | output | 64 | PC that produced the hit, valid with `hit` |

## Verification
A slot register corrupted by a bad write decode shows up on `rd_data` as soon as the write edge has passed. It also appears on the next probe of that address as a missing or unexpected `hit`. A fault in the enable, type or privilege decoding shows up one cycle after the probe that exercises it, as a wrong `hit`. A fault in the priority encoding or the output register shows as a wrong `hit_idx` or `hit_pc` in that same cycle. Back-to-back probes with different outcomes show any state that leaks from one probe to the next.

// File: rtl/bp_bank_pkg.sv
package bp_bank_pkg;

    localparam logic [31:0] CTL_KEEP_MASK = 32'h00FF_E1E7;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_PRV_LO  = 1;
    localparam int CTL_TYP_LO  = 20;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] ctl;
    } slot_regs_t;

    function automatic logic priv_allows(input logic [1:0] prv, input logic [1:0] el);
        logic ok;
        case (el)
            2'd0:    ok = prv[1];
            2'd1:    ok = prv[0];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bp_slot.sv
module bp_slot
    import bp_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_addr,
    input  logic        wr_ctl,
    input  logic [63:0] wdata,
    input  logic [63:0] pc,
    input  logic [1:0]  el,
    output logic [63:0] addr_q,
    output logic [31:0] ctl_q,
    output logic        match
);

    slot_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_addr) r_d.addr = wdata;
        if (wr_ctl)  r_d.ctl  = wdata[31:0] & CTL_KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr_q = r_q.addr;
    assign ctl_q  = r_q.ctl;

    always_comb begin
        match = r_q.ctl[CTL_EN_BIT]
             && (r_q.ctl[CTL_TYP_LO +: 4] == 4'd0)
             && priv_allows(r_q.ctl[CTL_PRV_LO +: 2], el)
             && (pc == r_q.addr);
    end

    assert_ctl_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTL_KEEP_MASK) == 32'd0);

endmodule

// File: rtl/bp_prio.sv
module bp_prio #(
    parameter int NUM   = 6,
    parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0]   req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = NUM - 1; k >= 0; k--) begin
            if (req[k]) begin
                any = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/bp_cmp_bank.sv
module bp_cmp_bank
    import bp_bank_pkg::*;
#(
    parameter int NUM   = 6,
    parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_sel,
    input  logic [63:0]      cfg_wdata,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_sel,
    output logic [63:0]      rd_data,
    input  logic             probe_valid,
    input  logic [63:0]      probe_pc,
    input  logic [1:0]       probe_el,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [63:0]      hit_pc
);

    localparam logic [IDX_W:0] NUM_L = NUM[IDX_W:0];

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [63:0]      pc;
    } out_regs_t;

    logic [63:0]    slot_addr [NUM];
    logic [31:0]    slot_ctl  [NUM];
    logic [NUM-1:0] slot_match;
    logic           any_match;
    logic [IDX_W-1:0] first_idx;

    for (genvar i = 0; i < NUM; i++) begin : g_slot
        logic sel_me;
        assign sel_me = cfg_we && (cfg_idx == IDX_W'(i));
        bp_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_addr (sel_me && !cfg_sel),
            .wr_ctl  (sel_me && cfg_sel),
            .wdata   (cfg_wdata),
            .pc      (probe_pc),
            .el      (probe_el),
            .addr_q  (slot_addr[i]),
            .ctl_q   (slot_ctl[i]),
            .match   (slot_match[i])
        );
    end

    bp_prio #(.NUM(NUM), .IDX_W(IDX_W)) u_prio (
        .req (slot_match),
        .any (any_match),
        .idx (first_idx)
    );

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM; k++) begin
            if (rd_idx == IDX_W'(k))
                rd_data = rd_sel ? {32'd0, slot_ctl[k]} : slot_addr[k];
        end
    end

    out_regs_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.hit = 1'b0;
        if (probe_valid && any_match) begin
            o_d.hit = 1'b1;
            o_d.idx = first_idx;
            o_d.pc  = probe_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hit     = o_q.hit;
    assign hit_idx = o_q.idx;
    assign hit_pc  = o_q.pc;

    assert_hit_needs_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(probe_valid));

    assert_hit_pc_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_pc == $past(probe_pc)));

    assert_hit_low_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(probe_el) < 2'd2));

    assert_hit_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ({1'b0, hit_idx} < NUM_L));

endmodule

// File: tb/test_bp_cmp_bank.sv
module test_bp_cmp_bank;

    localparam int NUM   = 6;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic             cfg_sel = 1'b0;
    logic [63:0]      cfg_wdata = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic             rd_sel = 1'b0;
    logic [63:0]      rd_data;
    logic             probe_valid = 1'b0;
    logic [63:0]      probe_pc = '0;
    logic [1:0]       probe_el = '0;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [63:0]      hit_pc;

    always #5 clk = ~clk;

    bp_cmp_bank #(.NUM(NUM), .IDX_W(IDX_W)) i_bp_cmp_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
        .rd_sel(rd_sel), .rd_data(rd_data), .probe_valid(probe_valid),
        .probe_pc(probe_pc), .probe_el(probe_el), .hit(hit),
        .hit_idx(hit_idx), .hit_pc(hit_pc)
    );

    typedef struct {
        logic             e_hit;
        logic [IDX_W-1:0] e_idx;
        logic [63:0]      e_pc;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check64({e.tag, " hit"}, {63'd0, hit}, {63'd0, e.e_hit});
            if (e.e_hit) begin
                check64({e.tag, " idx"}, {61'd0, hit_idx}, {61'd0, e.e_idx});
                check64({e.tag, " pc"}, hit_pc, e.e_pc);
            end
        end
    end

    task automatic wr(input int idx, input logic sel, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic sel, input logic [63:0] exp);
        rd_idx = IDX_W'(idx); rd_sel = sel;
        #1;
        check64(tag, rd_data, exp);
    endtask

    task automatic probe(input string tag, input logic v, input logic [63:0] pc, input logic [1:0] el,
                         input logic eh, input int ei);
        exp_t e;
        @(negedge clk);
        probe_valid = v; probe_pc = pc; probe_el = el;
        e.e_hit = eh; e.e_idx = IDX_W'(ei); e.e_pc = pc; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        probe_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check64("R1 hit after reset", {63'd0, hit}, 64'd0);
        rd_chk("R1 ctrl slot0", 0, 1'b1, 64'd0);
        rd_chk("R1 value slot5", 5, 1'b0, 64'd0);

        // R2 value write, R3 reserved bits dropped
        wr(2, 1'b0, 64'h0000_0000_0000_1000);
        rd_chk("R2 value slot2", 2, 1'b0, 64'h1000);
        wr(2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R3 ctrl masked", 2, 1'b1, 64'h0000_0000_00FF_E1E7);

        // R5 non-zero type blocks hit
        probe("R5 type nonzero", 1'b1, 64'h1000, 2'd1, 1'b0, 0);
        idle();

        // R2 ctrl write; plain match, PMC=11
        wr(2, 1'b1, 64'h1E7);
        rd_chk("R2 ctrl slot2", 2, 1'b1, 64'h1E7);
        probe("R6 pmc11 el0", 1'b1, 64'h1000, 2'd0, 1'b1, 2);
        probe("R6 pmc11 el1", 1'b1, 64'h1000, 2'd1, 1'b1, 2);
        probe("R6 pmc11 el2", 1'b1, 64'h1000, 2'd2, 1'b0, 0);
        probe("R6 pmc11 el3", 1'b1, 64'h1000, 2'd3, 1'b0, 0);
        probe("R7 off by 4", 1'b1, 64'h1004, 2'd1, 1'b0, 0);
        probe("R7 high bit", 1'b1, 64'h8000_0000_0000_1000, 2'd1, 1'b0, 0);
        probe("R9 valid low", 1'b0, 64'h1000, 2'd1, 1'b0, 0);
        idle();

        // R4 enable cleared
        wr(2, 1'b1, 64'h1E6);
        probe("R4 disabled", 1'b1, 64'h1000, 2'd1, 1'b0, 0);
        idle();

        // R6 other filters
        wr(2, 1'b1, 64'h1E3);
        probe("R6 pmc01 el1", 1'b1, 64'h1000, 2'd1, 1'b1, 2);
        probe("R6 pmc01 el0", 1'b1, 64'h1000, 2'd0, 1'b0, 0);
        idle();
        wr(2, 1'b1, 64'h1E5);
        probe("R6 pmc10 el0", 1'b1, 64'h1000, 2'd0, 1'b1, 2);
        probe("R6 pmc10 el1", 1'b1, 64'h1000, 2'd1, 1'b0, 0);
        idle();
        wr(2, 1'b1, 64'h1E1);
        probe("R6 pmc00 el0", 1'b1, 64'h1000, 2'd0, 1'b0, 0);
        probe("R6 pmc00 el1", 1'b1, 64'h1000, 2'd1, 1'b0, 0);
        idle();

        // R8 priority
        wr(2, 1'b1, 64'h1E7);
        wr(4, 1'b0, 64'h1000);
        wr(4, 1'b1, 64'h1E7);
        wr(0, 1'b0, 64'h2000);
        probe("R8 slots 2 and 4", 1'b1, 64'h1000, 2'd0, 1'b1, 2);
        idle();
        wr(1, 1'b0, 64'h1000);
        wr(1, 1'b1, 64'h1E7);
        probe("R8 slots 1 2 4", 1'b1, 64'h1000, 2'd1, 1'b1, 1);
        // R9 back-to-back with changing outcome
        probe("R9 b2b miss", 1'b1, 64'h2000, 2'd1, 1'b0, 0);
        probe("R9 b2b hit", 1'b1, 64'h1000, 2'd0, 1'b1, 1);
        idle();
        wr(0, 1'b1, 64'h1E7);
        probe("R9 slot0 pc copy", 1'b1, 64'h2000, 2'd0, 1'b1, 0);
        idle();

        // R10 out-of-range writes change no slot
        wr(6, 1'b0, 64'hDEAD_BEEF);
        wr(7, 1'b1, 64'h0);
        wr(6, 1'b1, 64'h0);
        rd_chk("R10 slot2 value kept", 2, 1'b0, 64'h1000);
        rd_chk("R10 slot3 value kept", 3, 1'b0, 64'h0);
        rd_chk("R10 slot2 ctrl kept", 2, 1'b1, 64'h1E7);
        rd_chk("R10 slot1 ctrl kept", 1, 1'b1, 64'h1E7);
        probe("R10 slot1 still hits", 1'b1, 64'h1000, 2'd1, 1'b1, 1);
        idle();
        idle();

        summary();
        $finish;
    end

endmodule